// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small 8-bit processor core: two external pins, two timer overflow flags and one serial port flag. Software sets a per-source enable mask, a master enable and a per-source priority mask. When an eligible source is pending, the block raises a request toward the core and drives the fixed 16-bit program address of that source's handler. The first handler address is 0003H, and the others follow at steps of 8 bytes. Address 0000H is never produced as a handler address.

The core pulses `ack` in the cycle in which it takes the request. The block then records the priority level of the granted source as being in service, and it clears the latched edge of that source if the source is an edge-mode external pin. The core pulses `reti` when it returns from a handler. This releases the most recent in-service level. A high-level source can interrupt a low-level handler. Nothing can interrupt a high-level handler. The timer and serial flags belong to their peripherals and are only observed here.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the enable mask, master enable, priority mask, edge latches and in-service levels are all clear. `irq_req` is 0, and `irq_vec` is 0000H whenever `irq_req` is 0.
- R2: The source index order is external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4. The granted source drives `irq_vec` = 0003H + 8 × index.
- R3: A write with `en_wr` loads `en_wdata`. Bits 4:0 enable the sources by index, and bit 5 is the master enable. While the master enable is 0, `irq_req` stays 0.
- R4: Among pending, enabled sources of the same level, the lowest index is granted.
- R5: A write with `pri_wr` loads `pri_wdata`. A bit set to 1 makes that source high level. An eligible high-level source is granted ahead of every low-level source, whatever their indices.
- R6: An `ack` while `irq_req` is 1 marks the granted source's level as in service. While only the low level is in service, low-level sources are withheld and high-level sources are still granted.
- R7: While the high level is in service, no source is granted.
- R8: A `reti` clears the high in-service level if it is set, and otherwise clears the low one.
- R9: With `ext_edge_mode` bit = 0, an external source is pending exactly while its active-low pin is 0. Nothing is latched.
- R10: With `ext_edge_mode` bit = 1, a 1-to-0 transition on the pin is latched one clock later. The latch holds after the pin returns high and is cleared by an `ack` that grants that source. A pin held low does not set the latch again.
- R11: The timer and serial flags are pending while high and are not cleared by `ack`.
- R12: An edge that arrives while its source is disabled is still latched, and it is requested once the source is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_n | input | 2 | External request pins, active low |
| ext_edge_mode | input | 2 | Per pin: 1 = falling-edge, 0 = level |
| tmr_ovf | input | 2 | Timer overflow flags (bit 0 = timer 0) |
| ser_flag | input | 1 | Serial port request flag |
| en_wr | input | 1 | Load enable register |
| en_wdata | input | 6 | Source enables [4:0], master enable [5] |
| pri_wr | input | 1 | Load priority register |
| pri_wdata | input | 5 | Per-source priority, 1 = high |
| ack | input | 1 | Core takes the current request |
| reti | input | 1 | Core returns from a handler |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Handler address of the granted source |

## Verification
The arbitration is swept over all 32 pending patterns against all 32 priority masks. This sweep separates the index order inside one level from the precedence of the high level over the low level. A second sweep covers all 32 enable masks with every source pending, which isolates masking from priority, and a check with the master enable cleared confirms that nothing is requested. Ordered sequences of ack and reti, each with a low-level handler and then a preempting high-level handler, show which level each return releases. External pins are exercised in level and edge mode with short pulses, held-low inputs and disabled sources, which separates latched requests from live ones. A separate case shows that the serial and timer flags survive an ack.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int SRC_N   = 5;
  localparam int EXT_N   = 2;
  localparam int IDX_W   = $clog2(SRC_N);
  localparam int VEC_W   = 16;

  typedef enum logic [IDX_W-1:0] {
    SRC_EX0 = 3'd0,
    SRC_TM0 = 3'd1,
    SRC_EX1 = 3'd2,
    SRC_TM1 = 3'd3,
    SRC_SER = 3'd4
  } src_e;

  typedef struct packed {
    logic             valid;
    logic             high;
    logic [IDX_W-1:0] idx;
  } grant_t;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic flag_q;
  logic fall;

  assign fall = prev_q & ~pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_n;
      if (!edge_mode)  flag_q <= 1'b0;
      else if (fall)   flag_q <= 1'b1;
      else if (clr)    flag_q <= 1'b0;
    end
  end

  assign pend = edge_mode ? flag_q : ~pin_n;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
#(
  parameter int N = SRC_N,
  parameter int W = IDX_W
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] en_mask,
  input  logic         glb_en,
  input  logic [N-1:0] pri_mask,
  input  logic         hi_busy,
  input  logic         lo_busy,
  output logic         gnt_valid,
  output logic         gnt_high,
  output logic [W-1:0] gnt_idx
);
  logic [N-1:0] live;
  logic [N-1:0] hi_cand;
  logic [N-1:0] lo_cand;

  always_comb begin
    live    = pend & en_mask & {N{glb_en & ~hi_busy}};
    hi_cand = live & pri_mask;
    lo_cand = live & ~pri_mask & {N{~lo_busy}};
    gnt_valid = |hi_cand | |lo_cand;
    gnt_high  = |hi_cand;
    gnt_idx   = '0;
    if (|hi_cand) begin
      for (int i = N - 1; i >= 0; i--)
        if (hi_cand[i]) gnt_idx = W'(i);
    end else begin
      for (int i = N - 1; i >= 0; i--)
        if (lo_cand[i]) gnt_idx = W'(i);
    end
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_high,
  input  logic ret,
  output logic hi_busy,
  output logic lo_busy
);
  logic hi_q, lo_q, hi_d, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (ret) begin
      if (hi_d) hi_d = 1'b0;
      else      lo_d = 1'b0;
    end
    if (take) begin
      if (take_high) hi_d = 1'b1;
      else           lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_busy = hi_q;
  assign lo_busy = lo_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0003,
  parameter int               VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXT_N-1:0] ext_n,
  input  logic [EXT_N-1:0] ext_edge_mode,
  input  logic [EXT_N-1:0] tmr_ovf,
  input  logic             ser_flag,
  input  logic             en_wr,
  input  logic [SRC_N:0]   en_wdata,
  input  logic             pri_wr,
  input  logic [SRC_N-1:0] pri_wdata,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  localparam int GLB_BIT = SRC_N;

  logic [SRC_N-1:0] en_src_q;
  logic             glb_q;
  logic [SRC_N-1:0] pri_q;
  logic [SRC_N-1:0] pend;
  logic [EXT_N-1:0] ext_pend;
  logic             hi_busy, lo_busy;
  grant_t           gnt;
  logic             take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_src_q <= '0;
      glb_q    <= 1'b0;
      pri_q    <= '0;
    end else begin
      if (en_wr) begin
        en_src_q <= en_wdata[SRC_N-1:0];
        glb_q    <= en_wdata[GLB_BIT];
      end
      if (pri_wr) pri_q <= pri_wdata;
    end
  end

  assign take = ack & gnt.valid;

  for (genvar g = 0; g < EXT_N; g++) begin : g_src
    irq_edge_latch u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (ext_n[g]),
      .edge_mode (ext_edge_mode[g]),
      .clr       (take && (gnt.idx == IDX_W'(2 * g))),
      .pend      (ext_pend[g])
    );
    assign pend[2*g]     = ext_pend[g];
    assign pend[2*g + 1] = tmr_ovf[g];
  end
  assign pend[SRC_N-1] = ser_flag;

  irq_arbiter #(.N(SRC_N), .W(IDX_W)) u_arb (
    .pend      (pend),
    .en_mask   (en_src_q),
    .glb_en    (glb_q),
    .pri_mask  (pri_q),
    .hi_busy   (hi_busy),
    .lo_busy   (lo_busy),
    .gnt_valid (gnt.valid),
    .gnt_high  (gnt.high),
    .gnt_idx   (gnt.idx)
  );

  irq_level_track u_lvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_high (gnt.high),
    .ret       (reti),
    .hi_busy   (hi_busy),
    .lo_busy   (lo_busy)
  );

  assign irq_req = gnt.valid;
  assign irq_vec = gnt.valid
                 ? VEC_BASE + VEC_W'(gnt.idx) * VEC_W'(VEC_STEP)
                 : '0;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_req,
  input logic [15:0] irq_vec,
  input logic        ack,
  input logic        reti,
  input logic        glb_en,
  input logic        hi_busy,
  input logic        lo_busy
);
  // R1
  idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_vec == 16'h0000);

  // R2
  vec_on_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'd3 && irq_vec <= 16'h0023));

  // R3
  master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_req);

  // R6
  take_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req) |=> (hi_busy || lo_busy));

  // R7
  high_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_busy |-> !irq_req);

  // R8
  ret_high_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && hi_busy) |=> (!hi_busy && $stable(lo_busy)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_req (irq_req),
  .irq_vec (irq_vec),
  .ack     (ack),
  .reti    (reti),
  .glb_en  (glb_q),
  .hi_busy (hi_busy),
  .lo_busy (lo_busy)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_n = 2'b11;
  logic [1:0]  ext_edge_mode = 2'b00;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        ser_flag = 1'b0;
  logic        en_wr = 1'b0;
  logic [5:0]  en_wdata = '0;
  logic        pri_wr = 1'b0;
  logic [4:0]  pri_wdata = '0;
  logic        ack = 1'b0;
  logic        reti = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge_mode(ext_edge_mode),
    .tmr_ovf(tmr_ovf), .ser_flag(ser_flag), .en_wr(en_wr), .en_wdata(en_wdata),
    .pri_wr(pri_wr), .pri_wdata(pri_wdata), .ack(ack), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // expected {req, vec} from pending, enables, priority and in-service state
  function automatic logic [16:0] model(input logic [4:0] p, input logic [5:0] e,
                                        input logic [4:0] pr, input bit hi, input bit lo);
    int best = -1;
    if (!e[5] || hi) return 17'd0;
    for (int i = 0; i < 5; i++)
      if (best < 0 && p[i] && e[i] && pr[i]) best = i;
    if (best < 0 && !lo)
      for (int i = 0; i < 5; i++)
        if (best < 0 && p[i] && e[i] && !pr[i]) best = i;
    if (best < 0) return 17'd0;
    return {1'b1, 16'(3 + 8 * best)};
  endfunction

  task automatic chk(input string rq, input logic er, input logic [15:0] ev);
    n_chk++;
    if (irq_req !== er || irq_vec !== ev) begin
      n_bad++;
      $display("FAIL %s: got req=%0b vec=%h, expected req=%0b vec=%h",
               rq, irq_req, irq_vec, er, ev);
    end
  endtask

  task automatic put_src(input logic [4:0] p);
    ext_n    = {~p[2], ~p[0]};
    tmr_ovf  = {p[3], p[1]};
    ser_flag = p[4];
  endtask

  task automatic wr_en(input logic [5:0] v);
    @(negedge clk); en_wr = 1'b1; en_wdata = v;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic wr_pri(input logic [4:0] v);
    @(negedge clk); pri_wr = 1'b1; pri_wdata = v;
    @(negedge clk); pri_wr = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0; #1;
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0; #1;
  endtask

  task automatic settle(input logic [4:0] p);
    @(negedge clk); put_src(p); #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [16:0] ex;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, sources pending but nothing enabled
    settle(5'b11111);
    chk("R1 reset", 1'b0, 16'h0000);

    // R3: master enable off blocks everything
    wr_en(6'b011111);
    settle(5'b11111);
    chk("R3 master off", 1'b0, 16'h0000);
    wr_en(6'b111111);

    // R2 R4 R5: sweep priority masks against pending patterns
    for (int pr = 0; pr < 32; pr++) begin
      wr_pri(5'(pr));
      for (int p = 0; p < 32; p++) begin
        settle(5'(p));
        ex = model(5'(p), 6'b111111, 5'(pr), 0, 0);
        chk("R2/R4/R5 sweep", ex[16], ex[15:0]);
      end
    end

    // R3: enable mask sweep, all pending, one level
    wr_pri(5'b00000);
    for (int e = 0; e < 32; e++) begin
      wr_en({1'b1, 5'(e)});
      settle(5'b11111);
      ex = model(5'b11111, {1'b1, 5'(e)}, 5'b0, 0, 0);
      chk("R3 enable sweep", ex[16], ex[15:0]);
    end
    wr_en(6'b111111);

    // R6 R7 R8: preemption sequence, serial high level
    wr_pri(5'b10000);
    settle(5'b00010);
    chk("R2 timer0", 1'b1, 16'h000B);
    do_ack();
    chk("R6 low busy withholds low", 1'b0, 16'h0000);
    settle(5'b00011);
    chk("R6 other low withheld", 1'b0, 16'h0000);
    settle(5'b10011);
    chk("R6 high preempts", 1'b1, 16'h0023);
    do_ack();
    chk("R7 high busy blocks", 1'b0, 16'h0000);
    do_reti();
    chk("R8 high released first", 1'b1, 16'h0023);
    settle(5'b00011);
    chk("R8 low still busy", 1'b0, 16'h0000);
    do_reti();
    chk("R8 low released", 1'b1, 16'h0003);
    settle(5'b00000);

    // R11: serial and timer flags survive ack
    wr_pri(5'b00000);
    settle(5'b10000);
    do_ack(); do_reti();
    chk("R11 serial kept", 1'b1, 16'h0023);
    settle(5'b01000);
    do_ack(); do_reti();
    chk("R11 timer1 kept", 1'b1, 16'h001B);
    settle(5'b00000);

    // R9: level mode follows pin, no latch
    settle(5'b00001);
    chk("R9 level low", 1'b1, 16'h0003);
    do_ack(); do_reti();
    chk("R9 level still low", 1'b1, 16'h0003);
    settle(5'b00000);
    chk("R9 level released", 1'b0, 16'h0000);

    // R10: edge mode on external 0
    @(negedge clk); ext_edge_mode = 2'b01;
    @(negedge clk); ext_n[0] = 1'b0; #1;
    chk("R10 edge not yet latched", 1'b0, 16'h0000);
    @(negedge clk); ext_n[0] = 1'b1; #1;
    chk("R10 edge latched and held", 1'b1, 16'h0003);
    do_ack(); do_reti();
    chk("R10 ack cleared latch", 1'b0, 16'h0000);
    @(negedge clk); ext_n[0] = 1'b0;
    @(negedge clk); #1;
    chk("R10 second edge", 1'b1, 16'h0003);
    do_ack(); do_reti();
    repeat (3) @(negedge clk);
    #1 chk("R10 held low no retrigger", 1'b0, 16'h0000);
    @(negedge clk); ext_n[0] = 1'b1;

    // R12: edge while disabled is kept
    @(negedge clk); ext_edge_mode = 2'b10;
    wr_en(6'b111011);
    @(negedge clk); ext_n[1] = 1'b0;
    @(negedge clk); ext_n[1] = 1'b1; #1;
    chk("R12 disabled no request", 1'b0, 16'h0000);
    wr_en(6'b111111);
    #1 chk("R12 request after enable", 1'b1, 16'h0013);
    do_ack(); do_reti();
    chk("R12 cleared by ack", 1'b0, 16'h0000);

    done = 1;
    summary();
    $finish;
  end
endmodule